// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the control sequencer of a small 8-bit processor core that handles the core's interrupt entry and exit. It takes the system reset, an edge-triggered non-maskable request, a level-sensitive maskable request and a software break reported by the instruction decoder. At each instruction boundary it decides whether to divert the core. When it diverts, it drives a simple synchronous memory bus on its own. It writes the return address and a status byte onto a stack in page one that grows downward. It then reads a two-byte vector from the top of the 64K space and hands the result to the core as the new program counter.

A return-from-interrupt reported by the decoder runs the reverse sequence. The status byte and then the return address are read back, and the mask flag is restored from the status byte. The decoder marks the second-to-last cycle of every instruction on `last2` and the boundary itself on `step`. A request must be visible before `last2` to be serviced at the coming boundary. The accumulator, the index registers and the arithmetic flags stay with the core. The sequencer only copies the core's flags into the pushed byte.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released the sequencer writes nothing. It reads 0xFFFC and then 0xFFFD and pulses `pc_load` in the second cycle after release, with `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}. The mask flag reads 1 and the stack pointer reads 0xFF.
- R2: An entry writes exactly three bytes. The high return-address byte goes to 0x0100+SP, the low byte to 0x0100+SP-1 and the status byte to 0x0100+SP-2. SP then reads 3 less (mod 256), and `pc_load` pulses in the sixth cycle after the boundary cycle.
- R3: A non-maskable entry loads PC from 0xFFFA (low) and 0xFFFB (high). Break and maskable entries both load it from 0xFFFE (low) and 0xFFFF (high), little-endian.
- R4: The pushed status byte copies `psw_in` except for three bits. Bit 2 holds the mask flag as it stands after the boundary's own set/clear. Bit 4 is 1 for a software break and 0 for hardware requests. Bit 5 is always 1.
- R5: Every entry leaves the mask flag set.
- R6: A maskable request (`irq_n` low) is taken only if the mask flag was clear before the boundary. While the mask is set, the request causes no bus writes and leaves SP unchanged.
- R7: The non-maskable request ignores the mask and is triggered by a falling edge of `nmi_n`. One edge gives one entry, however long the line stays low.
- R8: A request that first appears in the `last2` cycle or later is not serviced at the coming boundary. It is serviced at the next one.
- R9: When several requests are pending at one boundary, the non-maskable one is served first, then break, then maskable. A return-from-interrupt always runs at its own boundary, and pending hardware requests wait for the following boundary.
- R10: A return reads 0x0100+SP+1 (status), +2 (low PC) and +3 (high PC) with no writes. It pulses `sr_load` with the status byte in the second cycle and `pc_load` in the fourth. SP then reads 3 more, and the mask flag equals bit 2 of the pulled status.
- R11: `sei_req` sets and `cli_req` clears the mask flag at the boundary. The maskable decision at that same boundary still uses the old mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; release starts the reset-vector fetch |
| step | input | 1 | Instruction boundary marker from the decoder |
| last2 | input | 1 | Second-to-last cycle of the current instruction |
| nmi_n | input | 1 | Non-maskable request, active low, edge-triggered |
| irq_n | input | 1 | Maskable request, active low, level-sensitive |
| brk_req | input | 1 | Software break completes at this boundary |
| rti_req | input | 1 | Return-from-interrupt completes at this boundary |
| sei_req | input | 1 | Set mask at this boundary |
| cli_req | input | 1 | Clear mask at this boundary |
| pc_in | input | 16 | Core's return address at the boundary |
| psw_in | input | 8 | Core's arithmetic flags for the pushed status |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | `pc_out` is valid this cycle |
| sr_out | output | 8 | Pulled status byte |
| sr_load | output | 1 | `sr_out` is valid this cycle |
| sp | output | 8 | Stack pointer |
| imask | output | 1 | Maskable-request mask flag |
| busy | output | 1 | A sequence is running; the core stalls |

## Verification
The bench looks for the timing edges around the decision point. A non-maskable edge placed in the `last2` cycle must wait one extra instruction, and a design that samples at the boundary would service it early. A line held low must be serviced only once, and a level-triggered design would re-enter on every boundary. A clear-mask at the same boundary as a pending maskable request must not take that request yet. The bench also checks the pushed break bit and the shared vector, since swapping them makes a break and a hardware request look identical to the handler. It checks that a simultaneous return and request runs the pull first, because the wrong order corrupts the stack frame.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 8;

    localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;

    localparam int MASK_BIT = 2;
    localparam int BRK_BIT  = 4;
    localparam int ONE_BIT  = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_PUSH_H, S_PUSH_L, S_PUSH_P,
        S_VEC_LO, S_VEC_HI, S_VEC_END,
        S_PULL_P, S_PULL_L, S_PULL_H, S_PULL_END
    } seq_state_t;

    typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_BRK, SRC_IRQ} src_t;

    typedef struct packed {
        logic take;
        logic ret;
        src_t src;
    } grant_t;

    function automatic logic [AW-1:0] vec_of(input src_t s);
        return (s == SRC_NMI) ? VEC_NMI : VEC_IRQ;
    endfunction

    function automatic logic [DW-1:0] pack_status(input logic [DW-1:0] core,
                                                  input logic mask, input logic brk);
        logic [DW-1:0] s;
        s           = core;
        s[MASK_BIT] = mask;
        s[BRK_BIT]  = brk;
        s[ONE_BIT]  = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/irq_seq_req.sv
module irq_seq_req
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   nmi_n,
    input  logic   irq_n,
    input  logic   last2,
    input  logic   boundary,
    input  logic   idle,
    input  logic   brk_req,
    input  logic   rti_req,
    input  logic   imask,
    output grant_t grant
);
    logic nmi_prev, nmi_pend, nmi_snap, irq_line, irq_snap;
    logic nmi_fall, sample, take_nmi;

    assign nmi_fall = nmi_prev & ~nmi_n;
    assign sample   = last2 & idle;

    // return first, then NMI > break > maskable
    always_comb begin
        grant = '{take: 1'b0, ret: 1'b0, src: SRC_NONE};
        if (rti_req) begin
            grant.take = 1'b1;
            grant.ret  = 1'b1;
        end else if (nmi_snap) begin
            grant.take = 1'b1;
            grant.src  = SRC_NMI;
        end else if (brk_req) begin
            grant.take = 1'b1;
            grant.src  = SRC_BRK;
        end else if (irq_snap && !imask) begin
            grant.take = 1'b1;
            grant.src  = SRC_IRQ;
        end
    end

    assign take_nmi = boundary & grant.take & ~grant.ret & (grant.src == SRC_NMI);

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b1;
            nmi_pend <= 1'b0;
            nmi_snap <= 1'b0;
            irq_line <= 1'b0;
            irq_snap <= 1'b0;
        end else begin
            nmi_prev <= nmi_n;
            irq_line <= ~irq_n;
            if (sample) begin
                // only what was seen before the penultimate cycle is committed
                nmi_snap <= nmi_snap | nmi_pend;
                nmi_pend <= nmi_fall;
                irq_snap <= irq_line;
            end else begin
                nmi_pend <= nmi_pend | nmi_fall;
                if (take_nmi) nmi_snap <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter logic [7:0] PAGE    = 8'h01,
    parameter logic [7:0] SP_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  grant_t        grant,
    input  logic          sei_req,
    input  logic          cli_req,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] psw_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [AW-1:0] pc_out,
    output logic          pc_load,
    output logic [DW-1:0] sr_out,
    output logic          sr_load,
    output logic [7:0]    sp,
    output logic          imask,
    output logic          busy
);
    seq_state_t    state;
    logic [7:0]    sp_q;
    logic          mask_q, brk_q;
    logic [DW-1:0] lo_q;
    logic [AW-1:0] ret_q, vec_q;
    logic [7:0]    sp_inc;

    assign sp_inc = sp_q + 8'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_VEC_LO;
            vec_q  <= VEC_RST;
            sp_q   <= SP_INIT;
            mask_q <= 1'b1;
            brk_q  <= 1'b0;
            lo_q   <= '0;
            ret_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (boundary) begin
                    if (sei_req)      mask_q <= 1'b1;
                    else if (cli_req) mask_q <= 1'b0;
                    if (grant.take) begin
                        if (grant.ret) state <= S_PULL_P;
                        else begin
                            state <= S_PUSH_H;
                            vec_q <= vec_of(grant.src);
                            brk_q <= (grant.src == SRC_BRK);
                            ret_q <= pc_in;
                        end
                    end
                end
                S_PUSH_H:  begin sp_q <= sp_q - 8'd1; state <= S_PUSH_L; end
                S_PUSH_L:  begin sp_q <= sp_q - 8'd1; state <= S_PUSH_P; end
                S_PUSH_P:  begin sp_q <= sp_q - 8'd1; mask_q <= 1'b1; state <= S_VEC_LO; end
                S_VEC_LO:  state <= S_VEC_HI;
                S_VEC_HI:  begin lo_q <= mem_rdata; state <= S_VEC_END; end
                S_VEC_END: state <= S_IDLE;
                S_PULL_P:  begin sp_q <= sp_inc; state <= S_PULL_L; end
                S_PULL_L:  begin sp_q <= sp_inc; mask_q <= mem_rdata[MASK_BIT]; state <= S_PULL_H; end
                S_PULL_H:  begin sp_q <= sp_inc; lo_q <= mem_rdata; state <= S_PULL_END; end
                S_PULL_END: state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = vec_q;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (state)
            S_PUSH_H: begin mem_addr = {PAGE, sp_q}; mem_wdata = ret_q[15:8]; mem_we = 1'b1; end
            S_PUSH_L: begin mem_addr = {PAGE, sp_q}; mem_wdata = ret_q[7:0];  mem_we = 1'b1; end
            S_PUSH_P: begin
                mem_addr  = {PAGE, sp_q};
                mem_wdata = pack_status(psw_in, mask_q, brk_q);
                mem_we    = 1'b1;
            end
            S_VEC_HI: mem_addr = vec_q + 16'd1;
            S_PULL_P, S_PULL_L, S_PULL_H: mem_addr = {PAGE, sp_inc};
            default: mem_addr = vec_q;
        endcase
    end

    assign pc_out  = {mem_rdata, lo_q};
    assign pc_load = (state == S_VEC_END) || (state == S_PULL_END);
    assign sr_out  = mem_rdata;
    assign sr_load = (state == S_PULL_L);
    assign sp      = sp_q;
    assign imask   = mask_q;
    assign busy    = (state != S_IDLE);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter logic [7:0] SP_INIT    = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        last2,
    input  logic        nmi_n,
    input  logic        irq_n,
    input  logic        brk_req,
    input  logic        rti_req,
    input  logic        sei_req,
    input  logic        cli_req,
    input  logic [15:0] pc_in,
    input  logic [7:0]  psw_in,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic [15:0] pc_out,
    output logic        pc_load,
    output logic [7:0]  sr_out,
    output logic        sr_load,
    output logic [7:0]  sp,
    output logic        imask,
    output logic        busy
);
    grant_t grant;
    logic   boundary;

    assign boundary = step & ~busy;

    irq_seq_req u_req (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .last2(last2),
        .boundary(boundary), .idle(~busy), .brk_req(brk_req), .rti_req(rti_req),
        .imask(imask), .grant(grant)
    );

    irq_seq_fsm #(.PAGE(STACK_PAGE), .SP_INIT(SP_INIT)) u_fsm (
        .clk(clk), .rst(rst), .boundary(boundary), .grant(grant),
        .sei_req(sei_req), .cli_req(cli_req), .pc_in(pc_in), .psw_in(psw_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .pc_out(pc_out), .pc_load(pc_load), .sr_out(sr_out),
        .sr_load(sr_load), .sp(sp), .imask(imask), .busy(busy)
    );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
#(
    parameter logic [7:0] PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  sp,
    input logic        imask,
    input logic        sr_load,
    input logic        busy,
    input logic        boundary,
    input grant_t      grant
);
    // R2: pushes land in the stack page
    p_stack_page_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[15:8] == PAGE);

    // R2: each push moves the pointer down by one
    p_push_dec_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sp == $past(sp) - 8'd1);

    // R5: mask is set once the push burst ends
    p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we) |-> imask);

    // R6: a maskable grant never occurs with the mask set
    p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        (boundary && grant.take && !grant.ret && grant.src == SRC_IRQ) |-> !imask);

    // R10: status pull happens inside a sequence without writes
    p_pull_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        sr_load |-> (!mem_we && busy));

endmodule

bind irq_entry_seq irq_seq_chk #(.PAGE(STACK_PAGE)) u_chk (
    .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr), .sp(sp),
    .imask(imask), .sr_load(sr_load), .busy(busy), .boundary(boundary), .grant(grant)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 0, last2 = 0, nmi_n = 1, irq_n = 1;
    logic        brk_req = 0, rti_req = 0, sei_req = 0, cli_req = 0;
    logic [15:0] pc_in = 16'h1234;
    logic [7:0]  psw_in = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, sr_out, sp;
    logic        mem_we, pc_load, sr_load, imask, busy;

    always #10 clk = ~clk;  // 50 MHz

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .step(step), .last2(last2), .nmi_n(nmi_n), .irq_n(irq_n),
        .brk_req(brk_req), .rti_req(rti_req), .sei_req(sei_req), .cli_req(cli_req),
        .pc_in(pc_in), .psw_in(psw_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_out(pc_out), .pc_load(pc_load),
        .sr_out(sr_out), .sr_load(sr_load), .sp(sp), .imask(imask), .busy(busy)
    );

    // memory: stack page and the six vector bytes, 0xEA elsewhere
    logic [7:0] stack_mem [256];
    logic [7:0] vec_m [6];
    initial for (int i = 0; i < 256; i++) stack_mem[i] = 8'h00;

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (a[15:8] == 8'h01) return stack_mem[a[7:0]];
        if (a >= 16'hFFFA)    return vec_m[a - 16'hFFFA];
        return 8'hEA;
    endfunction

    always @(posedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) stack_mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= rd(mem_addr);
    end

    // write log
    int         nw = 0;
    logic [15:0] wr_a [8];
    logic [7:0]  wr_d [8];
    always @(negedge clk) begin
        if (!rst && mem_we && nw < 8) begin
            wr_a[nw] = mem_addr;
            wr_d[nw] = mem_wdata;
            nw++;
        end
    end

    int ntot = 0, nbad = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model
    logic [7:0] model_stk [256];
    logic [7:0] sp_m = 8'hFF;
    logic       imask_m = 1'b1;
    int         depth = 0;
    int         lat, nsr;
    logic       busy1;
    logic [15:0] got_pc;
    logic [7:0]  got_sr;
    initial for (int i = 0; i < 256; i++) model_stk[i] = 8'h00;

    function automatic logic [7:0] stat_of(input logic [7:0] p, input logic m, input logic b);
        return (p & 8'hCB) | 8'h20 | {5'b0, m, 2'b0} | {3'b0, b, 4'b0};
    endfunction

    function automatic logic [15:0] vec_val(input logic [15:0] base);
        int i;
        i = base - 16'hFFFA;
        return {vec_m[i+1], vec_m[i]};
    endfunction

    task automatic run_instr(input bit b_brk, input bit b_rti, input bit b_sei,
                             input bit b_cli, input bit late_nmi);
        nw = 0; nsr = 0; lat = 0; busy1 = 0;
        @(negedge clk);
        last2 = 1;
        if (late_nmi) nmi_n = 0;
        @(negedge clk);
        last2 = 0; step = 1;
        brk_req = b_brk; rti_req = b_rti; sei_req = b_sei; cli_req = b_cli;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 1) begin
                step = 0; brk_req = 0; rti_req = 0; sei_req = 0; cli_req = 0;
                busy1 = busy;
            end
            if (pc_load && lat == 0) begin lat = n; got_pc = pc_out; end
            if (sr_load) begin nsr++; got_sr = sr_out; end
        end
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi_n = 0;
        @(negedge clk); nmi_n = 1;
    endtask

    task automatic check_entry(input string tag, input logic [15:0] vbase, input bit b);
        logic [7:0] st;
        st = stat_of(psw_in, imask_m, b);
        chk({tag, " R2 latency"}, lat, 6);
        chk({tag, " R2 write count"}, nw, 3);
        chk({tag, " R2 addr hi"}, wr_a[0], {8'h01, sp_m});
        chk({tag, " R2 data hi"}, wr_d[0], pc_in[15:8]);
        chk({tag, " R2 addr lo"}, wr_a[1], {8'h01, sp_m - 8'd1});
        chk({tag, " R2 data lo"}, wr_d[1], pc_in[7:0]);
        chk({tag, " R2 addr status"}, wr_a[2], {8'h01, sp_m - 8'd2});
        chk({tag, " R4 status byte"}, wr_d[2], st);
        model_stk[sp_m]         = pc_in[15:8];
        model_stk[sp_m - 8'd1]  = pc_in[7:0];
        model_stk[sp_m - 8'd2]  = st;
        sp_m    = sp_m - 8'd3;
        imask_m = 1'b1;
        depth++;
        chk({tag, " R3 vector"}, got_pc, vec_val(vbase));
        chk({tag, " R2 sp"}, sp, sp_m);
        chk({tag, " R5 mask set"}, imask, 1);
    endtask

    task automatic check_none(input string tag);
        chk({tag, " no entry busy"}, busy1, 0);
        chk({tag, " no writes"}, nw, 0);
        chk({tag, " sp kept"}, sp, sp_m);
        chk({tag, " mask"}, imask, imask_m);
    endtask

    task automatic check_rti(input string tag);
        logic [7:0] s, lo, hi;
        s  = model_stk[sp_m + 8'd1];
        lo = model_stk[sp_m + 8'd2];
        hi = model_stk[sp_m + 8'd3];
        chk({tag, " R10 latency"}, lat, 4);
        chk({tag, " R10 no writes"}, nw, 0);
        chk({tag, " R10 sr_load count"}, nsr, 1);
        chk({tag, " R10 status"}, got_sr, s);
        chk({tag, " R10 pc"}, got_pc, {hi, lo});
        sp_m    = sp_m + 8'd3;
        imask_m = s[2];
        depth--;
        chk({tag, " R10 sp"}, sp, sp_m);
        chk({tag, " R10 mask restored"}, imask, imask_m);
    endtask

    task automatic randomize_ctx();
        for (int i = 0; i < 6; i++) vec_m[i] = 8'($urandom);
        pc_in  = 16'($urandom);
        psw_in = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        vec_m[0] = 8'h34; vec_m[1] = 8'h12;  // NMI
        vec_m[2] = 8'h00; vec_m[3] = 8'h10;  // reset -> 0x1000
        vec_m[4] = 8'hCD; vec_m[5] = 8'hAB;  // IRQ/BRK

        // R1: reset fetch
        nw = 0; lat = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            if (pc_load && lat == 0) begin lat = n; got_pc = pc_out; end
        end
        chk("R1 latency", lat, 2);
        chk("R1 vector", got_pc, 16'h1000);
        chk("R1 no writes", nw, 0);
        chk("R1 sp", sp, 8'hFF);
        chk("R1 mask", imask, 1);

        // R6: masked request ignored
        irq_n = 0;
        run_instr(0, 0, 0, 0, 0);
        check_none("R6 masked");

        // R11 + R6: clear at the boundary does not take the request yet
        run_instr(0, 0, 0, 1, 0);
        imask_m = 0;
        check_none("R11 cli same boundary");
        run_instr(0, 0, 0, 0, 0);
        check_entry("R6 irq entry", 16'hFFFE, 0);
        irq_n = 1;

        // R10: return
        run_instr(0, 1, 0, 0, 0);
        check_rti("R10 return");

        // R7: NMI with mask set, held low gives one entry
        run_instr(0, 0, 1, 0, 0);
        imask_m = 1;
        check_none("R11 sei");
        @(negedge clk); nmi_n = 0;
        run_instr(0, 0, 0, 0, 0);
        check_entry("R7 nmi masked", 16'hFFFA, 0);
        run_instr(0, 0, 0, 0, 0);
        check_none("R7 held low");
        nmi_n = 1;

        // R8: edge in the penultimate cycle waits one instruction
        run_instr(0, 0, 0, 0, 1);
        nmi_n = 1;
        check_none("R8 late nmi deferred");
        run_instr(0, 0, 0, 0, 0);
        check_entry("R8 late nmi serviced", 16'hFFFA, 0);

        // R4: software break
        psw_in = 8'hC3;
        run_instr(1, 0, 0, 0, 0);
        check_entry("R4 brk", 16'hFFFE, 1);

        // R9: NMI beats break and maskable
        run_instr(0, 0, 0, 1, 0);
        imask_m = 0;
        check_none("R9 prep cli");
        irq_n = 0;
        nmi_pulse();
        run_instr(1, 0, 0, 0, 0);
        check_entry("R9 nmi wins", 16'hFFFA, 0);
        irq_n = 1;

        // R9: return runs before a pending NMI
        nmi_pulse();
        run_instr(0, 1, 0, 0, 0);
        check_rti("R9 rti first");
        run_instr(0, 0, 0, 0, 0);
        check_entry("R9 nmi after rti", 16'hFFFA, 0);

        // random mix
        for (int it = 0; it < 150; it++) begin
            int k;
            randomize_ctx();
            k = int'($urandom % 5);
            case (k)
                0: begin nmi_pulse(); run_instr(0, 0, 0, 0, 0); check_entry("R7 rnd nmi", 16'hFFFA, 0); end
                1: begin run_instr(1, 0, 0, 0, 0); check_entry("R3 rnd brk", 16'hFFFE, 1); end
                2: begin
                    if (imask_m) begin
                        run_instr(0, 0, 0, 1, 0); imask_m = 0; check_none("R11 rnd cli");
                    end
                    @(negedge clk); irq_n = 0;
                    run_instr(0, 0, 0, 0, 0);
                    check_entry("R6 rnd irq", 16'hFFFE, 0);
                    irq_n = 1;
                end
                3: begin
                    if (depth > 0) begin run_instr(0, 1, 0, 0, 0); check_rti("R10 rnd rti"); end
                end
                default: begin
                    bit s;
                    s = 1'($urandom);
                    run_instr(0, 0, s, !s, 0);
                    imask_m = s;
                    check_none("R11 rnd mask");
                end
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            ntot++; nbad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

endmodule